// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Timer

This block drives the active-low reset of a host processor from three causes: the power-on start, a supply-low indication and a watchdog expiry. A digital supply-good flag stands in for the analog comparator. Whenever the flag is low, reset goes active. Reset is released only after the flag has been high without a break for a fixed hold time, nominally 200 ms, counted in system clock cycles.

The watchdog shares its input with the chip-select pin of the serial port. The host restarts the watchdog by driving that pin from high to low. A two-bit selection picks one of three timeout periods, or turns the watchdog off. When the chosen period runs out with no falling edge, reset is driven active for the same hold time and then released. The watchdog then starts again from zero.

All intervals are parameters given in clock cycles, so a bench can scale them down. The defaults assume a 32.768 kHz time base.

Top module: `sup_reset_wdog`

## Requirements
- R1: rst_out_n is active low. It is low while arst_n is low. After arst_n rises with supply_ok held high, it stays low for HOLD_CYC+1 rising edges and is high after the (HOLD_CYC+2)-th edge.
- R2: If supply_ok is sampled low at a rising edge, rst_out_n is low after that edge.
- R3: Once running, rst_out_n goes high after the HOLD_CYC-th consecutive edge at which supply_ok is sampled high while reset is active. Any low sample restarts the count.
- R4: per_sel selects the watchdog period: 2'b00 gives WD_LONG_CYC, 2'b01 gives WD_MID_CYC, 2'b10 gives WD_SHORT_CYC and 2'b11 turns the watchdog off.
- R5: A high-to-low transition on wdi restarts the watchdog count. If wdi is first sampled low at edge e, after at least two high samples, the count is zero after edge e+2.
- R6: Holding wdi steady high or steady low never restarts the count.
- R7: With the watchdog enabled and no restart, rst_out_n falls after the P-th edge following the release edge, where P is the selected period. It is still high after edge P-1.
- R8: A watchdog timeout holds rst_out_n low for HOLD_CYC edges and then releases it.
- R9: With per_sel = 2'b11, rst_out_n never falls while supply_ok stays high.
- R10: The watchdog count is held at zero while reset is active. After every release, a full period must pass again before the next timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| supply_ok | input | 1 | Supply-good flag from the comparator, high when the supply is above the trip point |
| wdi | input | 1 | Watchdog kick input, shared with chip select; may change asynchronously |
| per_sel | input | 2 | Watchdog period selection (see R4) |
| rst_out_n | output | 1 | Active-low reset to the host processor |

## Verification
The properties assume that supply_ok and per_sel are synchronous to clk, and that per_sel does not change while the watchdog is counting. Only wdi passes through a synchroniser. The bench changes every input on the falling clock edge. It sets per_sel only while the logic is held in reset, and it toggles supply_ok only between edges. The expected edge counts therefore follow directly from R1 to R10.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/sup_wdi_edge.sv
module sup_wdi_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_i,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for the edge detector
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], wdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign fall_o = chain_q[LEN-1] & ~chain_q[LEN-2];
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int HOLD_CYC = 6554,
  parameter int W        = $clog2(HOLD_CYC + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok_i,
  input  logic         trip_i,
  output logic         rel_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(HOLD_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         rel_q, rel_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    cnt_en = 1'b0;
    if (!supply_ok_i || trip_i) begin
      cnt_d  = '0;
      rel_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (!rel_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d = '0;
        rel_d = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign rel_o = rel_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_wdog_timer.sv
module sup_wdog_timer
  import sup_pkg::*;
#(
  parameter int SHORT_CYC = 6554,
  parameter int MID_CYC   = 19661,
  parameter int LONG_CYC  = 45875,
  parameter int W         = $clog2(LONG_CYC + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  wd_sel_e      sel_i,
  input  logic         kick_i,
  output logic         trip_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] lim;
  logic         en;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    en = 1'b1;
    unique case (sel_i)
      WD_LONG:  lim = W'(LONG_CYC - 1);
      WD_MID:   lim = W'(MID_CYC - 1);
      WD_SHORT: lim = W'(SHORT_CYC - 1);
      default: begin
        lim = '0;
        en  = 1'b0;
      end
    endcase
  end

  assign trip_o = run_i && en && !kick_i && (cnt_q >= lim);

  always_comb begin
    if (!run_i || !en || kick_i || trip_o) cnt_d = '0;
    else                                   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog
  import sup_pkg::*;
#(
  parameter int HOLD_CYC     = 6554,
  parameter int WD_SHORT_CYC = 6554,
  parameter int WD_MID_CYC   = 19661,
  parameter int WD_LONG_CYC  = 45875,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_ok,
  input  logic       wdi,
  input  logic [1:0] per_sel,
  output logic       rst_out_n
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int WD_W   = $clog2(WD_LONG_CYC + 1);

  logic              rst_sync_n;
  logic              wd_kick;
  logic              wd_trip;
  logic              released;
  logic [HOLD_W-1:0] hold_cnt;
  logic [WD_W-1:0]   wd_cnt;

  sup_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  sup_wdi_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wdi_i  (wdi),
    .fall_o (wd_kick)
  );

  sup_hold_timer #(.HOLD_CYC(HOLD_CYC), .W(HOLD_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .supply_ok_i (supply_ok),
    .trip_i      (wd_trip),
    .rel_o       (released),
    .cnt_o       (hold_cnt)
  );

  sup_wdog_timer #(
    .SHORT_CYC (WD_SHORT_CYC),
    .MID_CYC   (WD_MID_CYC),
    .LONG_CYC  (WD_LONG_CYC),
    .W         (WD_W)
  ) u_wdog (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (released),
    .sel_i  (wd_sel_e'(per_sel)),
    .kick_i (wd_kick),
    .trip_o (wd_trip),
    .cnt_o  (wd_cnt)
  );

  assign rst_out_n = released;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk #(
  parameter int HOLD_CYC = 6554,
  parameter int HOLD_W   = 13,
  parameter int WD_W     = 16
) (
  input logic              clk,
  input logic              arst_n,
  input logic              supply_ok,
  input logic [1:0]        per_sel,
  input logic              rst_out_n,
  input logic              wd_kick,
  input logic [HOLD_W-1:0] hold_cnt,
  input logic [WD_W-1:0]   wd_cnt
);
  a_r2_supply_low: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !rst_out_n);

  a_r3_release_supply: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> $past(supply_ok));

  a_r3_release_count: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> $past(hold_cnt) == HOLD_W'(HOLD_CYC - 1));

  a_r10_wd_cleared: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_out_n |=> wd_cnt == '0);

  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (wd_kick && rst_out_n) |=> wd_cnt == '0);

  a_r9_off_no_trip: assert property (@(posedge clk) disable iff (!arst_n)
    (per_sel == 2'b11 && supply_ok && rst_out_n) |=> rst_out_n);
endmodule

bind sup_reset_wdog sup_reset_wdog_chk #(
  .HOLD_CYC (HOLD_CYC),
  .HOLD_W   (HOLD_W),
  .WD_W     (WD_W)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .supply_ok (supply_ok),
  .per_sel   (per_sel),
  .rst_out_n (rst_out_n),
  .wd_kick   (wd_kick),
  .hold_cnt  (hold_cnt),
  .wd_cnt    (wd_cnt)
);

// File: tb/sup_reset_wdog_test.sv
module sup_reset_wdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD  = 20;
  localparam int SHORT = 30;
  localparam int MID   = 50;
  localparam int LONG  = 80;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] wait_n;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b10, 16'd29,  1'b1},
    '{2'b10, 16'd30,  1'b0},
    '{2'b01, 16'd49,  1'b1},
    '{2'b01, 16'd50,  1'b0},
    '{2'b00, 16'd79,  1'b1},
    '{2'b00, 16'd80,  1'b0},
    '{2'b11, 16'd200, 1'b1}
  };

  logic       clk = 1'b0;
  logic       arst_n;
  logic       supply_ok;
  logic       wdi;
  logic [1:0] per_sel;
  logic       rst_out_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_wdog #(
    .HOLD_CYC     (HOLD),
    .WD_SHORT_CYC (SHORT),
    .WD_MID_CYC   (MID),
    .WD_LONG_CYC  (LONG)
  ) uut (
    .clk       (clk),
    .arst_n    (arst_n),
    .supply_ok (supply_ok),
    .wdi       (wdi),
    .per_sel   (per_sel),
    .rst_out_n (rst_out_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_out_n=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reset the logic with supply good and wdi high; returns at the negedge after release.
  task automatic power_up(input logic [1:0] sel);
    arst_n    = 1'b0;
    supply_ok = 1'b1;
    wdi       = 1'b1;
    per_sel   = sel;
    step(3);
    arst_n = 1'b1;
    step(HOLD + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run hung, rst_out_n=%0b expected completion", rst_out_n);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; supply_ok = 1'b1; wdi = 1'b1; per_sel = 2'b10;
    step(3);
    chk("R1 held in reset", rst_out_n, 1'b0);
    arst_n = 1'b1;
    step(HOLD + 1);
    chk("R1 power-up still low", rst_out_n, 1'b0);
    step(1);
    chk("R1 power-up release", rst_out_n, 1'b1);

    // R4 R7 R9: period per selection code, wdi held steady high
    foreach (VECS[i]) begin
      power_up(VECS[i].sel);
      step(int'(VECS[i].wait_n));
      chk($sformatf("R4 R7 R9 vec %0d", i), rst_out_n, VECS[i].exp);
    end

    // R5: exact restart timing after one falling edge
    power_up(2'b10);
    step(10);
    wdi = 1'b0;
    step(32);
    chk("R5 kick restarts count", rst_out_n, 1'b1);
    step(1);
    chk("R5 timeout after kick", rst_out_n, 1'b0);

    // R5: periodic kicks keep reset released
    power_up(2'b10);
    begin
      logic ok = 1'b1;
      for (int k = 0; k < 20; k++) begin
        wdi = 1'b0;
        for (int j = 0; j < 10; j++) begin step(1); if (!rst_out_n) ok = 1'b0; end
        wdi = 1'b1;
        for (int j = 0; j < 10; j++) begin step(1); if (!rst_out_n) ok = 1'b0; end
      end
      chk("R5 periodic kicks", ok, 1'b1);
    end

    // R6: steady low after one edge does not keep restarting
    power_up(2'b10);
    wdi = 1'b0;
    step(40);
    chk("R6 steady low times out", rst_out_n, 1'b0);

    // R8 R10: timeout hold, release, fresh full period
    power_up(2'b10);
    step(30);
    chk("R8 timeout asserted", rst_out_n, 1'b0);
    step(HOLD - 1);
    chk("R8 hold still low", rst_out_n, 1'b0);
    step(1);
    chk("R8 released after hold", rst_out_n, 1'b1);
    step(29);
    chk("R10 full period again", rst_out_n, 1'b1);
    step(1);
    chk("R10 second timeout", rst_out_n, 1'b0);

    // R2 R3: supply drop and restart of hold count
    power_up(2'b11);
    supply_ok = 1'b0;
    step(1);
    chk("R2 supply low asserts", rst_out_n, 1'b0);
    supply_ok = 1'b1;
    step(10);
    supply_ok = 1'b0;
    step(1);
    supply_ok = 1'b1;
    step(HOLD - 1);
    chk("R3 glitch restarts hold", rst_out_n, 1'b0);
    step(1);
    chk("R3 release after hold", rst_out_n, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule